// File: doc/BRIEF.md
# Load-Use Stall and Operand Bypass Unit

This block is the hazard logic of a five-stage in-order pipeline whose pipeline registers are named after the stage boundaries: IF/ID, ID/EX, EX/MEM, MEM/WB, and an extra WB/END latch that keeps one more retired result. The block is purely combinational. It looks at the five instruction words and the data they carry. It raises a stall flag when the instruction now being decoded would read the register that a load one stage ahead is about to fetch. It also replaces the two register-file read values of the instruction in ID/EX with newer results that are still travelling down the pipeline.

The surrounding pipeline uses the stall flag itself. While the flag is high it holds the PC and IF/ID and loads a no-op into ID/EX. The two resolved operands feed the execute stage directly. Branch flushing and the register file sit outside the block.

Instruction fields are at fixed positions:
- opcode in bits 24:22
- first source (operand A) in bits 21:19
- second source (operand B) in bits 18:16
- arithmetic destination in bits 2:0

The opcode values are add 0, nor 1, load 2, store 3, branch-if-equal 4, jump-and-link 5, halt 6 and no-op 7.

Top module: `hzfwd_unit`

## Requirements
- R1: `stall` is 0 whenever the ID/EX opcode (bits 24:22) is not 2 (load).
- R2: When the ID/EX opcode is 2, `stall` is 1 exactly when its bits 18:16 equal bits 21:19 or bits 18:16 of the IF/ID word. The IF/ID opcode plays no part in this.
- R3: Add (0) and nor (1) write the register in bits 2:0. A load (2) writes the register in bits 18:16. Opcodes 3 to 7 write nothing.
- R4: If no downstream stage writes the register named by an ID/EX source field, that operand equals its register-file read value (`rf_a` for bits 21:19, `rf_b` for bits 18:16).
- R5: The two operands are resolved independently. Each may take its value from a different stage in the same cycle.
- R6: When several stages write the same register, the youngest wins: EX/MEM over MEM/WB over WB/END.
- R7: A match in EX/MEM supplies `exmem_alu`. A match in MEM/WB supplies `memwb_wdata`. A match in WB/END supplies `wbend_wdata`.
- R8: A load in EX/MEM is never a bypass source, even when its bits 18:16 match. An older matching stage or the register file supplies the operand instead.
- R9: Stages holding store, branch, jump-and-link, halt or no-op never supply an operand, whatever their bits 2:0 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_instr | input | 32 | Instruction word in IF/ID |
| idex_instr | input | 32 | Instruction word in ID/EX |
| exmem_instr | input | 32 | Instruction word in EX/MEM |
| memwb_instr | input | 32 | Instruction word in MEM/WB |
| wbend_instr | input | 32 | Instruction word in WB/END |
| exmem_alu | input | 32 | ALU result held in EX/MEM |
| memwb_wdata | input | 32 | Write-back data held in MEM/WB |
| wbend_wdata | input | 32 | Write-back data held in WB/END |
| rf_a | input | 32 | Register-file value for ID/EX bits 21:19 |
| rf_b | input | 32 | Register-file value for ID/EX bits 18:16 |
| stall | output | 1 | Load-use stall request |
| opnd_a | output | 32 | Resolved first operand of ID/EX |
| opnd_b | output | 32 | Resolved second operand of ID/EX |

## Verification
The in-line checks assume that every input is a known value whenever it is evaluated. They also assume that the opcode field is meaningful only in bits 24:22, so bits above 24 are always zero. The stimulus drives every input from defined initial values. It builds each instruction word from an opcode, three register fields and a random 16-bit low field, with the upper bits cleared. Random register fields are drawn from all eight registers, so matches between stages happen often. Directed vectors cover every pairing of sources for the two operands, together with the load and non-writing cases.

// File: rtl/hzfwd_pkg.sv
package hzfwd_pkg;
    localparam int OPC_LSB = 22;
    localparam int OPC_W   = 3;
    localparam int RA_LSB  = 19;
    localparam int RB_LSB  = 16;
    localparam int DST_LSB = 0;
    localparam int IDX_W   = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD    = 3'd0,
        OP_NOR    = 3'd1,
        OP_LOAD   = 3'd2,
        OP_STORE  = 3'd3,
        OP_BRANCH = 3'd4,
        OP_LINK   = 3'd5,
        OP_STOP   = 3'd6,
        OP_IDLE   = 3'd7
    } opc_e;

    typedef struct packed {
        opc_e             opc;
        logic [IDX_W-1:0] ra;
        logic [IDX_W-1:0] rb;
        logic [IDX_W-1:0] dst;
        logic             wr;
    } dec_t;
endpackage

// File: rtl/hzfwd_decode.sv
module hzfwd_decode
    import hzfwd_pkg::*;
#(
    parameter int INSTR_W  = 32,
    parameter bit LOAD_FWD = 1'b1
) (
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    dec_t dec_d;

    always_comb begin
        dec_d     = '0;
        dec_d.opc = opc_e'(instr[OPC_LSB +: OPC_W]);
        dec_d.ra  = instr[RA_LSB +: IDX_W];
        dec_d.rb  = instr[RB_LSB +: IDX_W];
        unique case (dec_d.opc)
            OP_ADD, OP_NOR: begin
                dec_d.dst = instr[DST_LSB +: IDX_W];
                dec_d.wr  = 1'b1;
            end
            OP_LOAD: begin
                // R3: load destination is the second register field
                dec_d.dst = instr[RB_LSB +: IDX_W];
                dec_d.wr  = LOAD_FWD;
            end
            default: begin
                dec_d.dst = '0;
                dec_d.wr  = 1'b0;
            end
        endcase
    end

    assign dec = dec_d;

    always_comb begin
        if (dec.wr)
            assert_dest_kind_R3: assert (dec.opc inside {OP_ADD, OP_NOR, OP_LOAD})
                else $error("writer decode on non-writing opcode");
    end
endmodule

// File: rtl/hzfwd_stall.sv
module hzfwd_stall
    import hzfwd_pkg::*;
(
    input  dec_t front,
    input  dec_t back,
    output logic stall
);
    logic stall_d;

    always_comb begin
        stall_d = 1'b0;
        if (back.opc == OP_LOAD) begin
            if ((back.rb == front.ra) || (back.rb == front.rb))
                stall_d = 1'b1;
        end
    end

    assign stall = stall_d;
endmodule

// File: rtl/hzfwd_pick.sv
module hzfwd_pick
    import hzfwd_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_SRC = 3
) (
    input  logic [IDX_W-1:0]  want,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [NUM_SRC-1:0] src_ok,
    input  logic [IDX_W-1:0]  src_dst [NUM_SRC],
    input  logic [DATA_W-1:0] src_val [NUM_SRC],
    output logic [DATA_W-1:0] picked
);
    logic [DATA_W-1:0] picked_d;

    // Sources are ordered oldest first; a later match overrides (R6).
    always_comb begin
        picked_d = rf_val;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_ok[i] && (src_dst[i] == want))
                picked_d = src_val[i];
        end
    end

    assign picked = picked_d;
endmodule

// File: rtl/hzfwd_unit.sv
module hzfwd_unit
    import hzfwd_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int DATA_W  = 32
) (
    input  logic [INSTR_W-1:0] ifid_instr,
    input  logic [INSTR_W-1:0] idex_instr,
    input  logic [INSTR_W-1:0] exmem_instr,
    input  logic [INSTR_W-1:0] memwb_instr,
    input  logic [INSTR_W-1:0] wbend_instr,
    input  logic [DATA_W-1:0]  exmem_alu,
    input  logic [DATA_W-1:0]  memwb_wdata,
    input  logic [DATA_W-1:0]  wbend_wdata,
    input  logic [DATA_W-1:0]  rf_a,
    input  logic [DATA_W-1:0]  rf_b,
    output logic               stall,
    output logic [DATA_W-1:0]  opnd_a,
    output logic [DATA_W-1:0]  opnd_b
);
    localparam int NUM_SRC  = 3;
    localparam int NUM_OPND = 2;
    localparam int SRC_WB   = 0;
    localparam int SRC_MW   = 1;
    localparam int SRC_EM   = 2;

    dec_t dec_ifid, dec_idex, dec_em, dec_mw, dec_wb;

    hzfwd_decode #(.INSTR_W(INSTR_W), .LOAD_FWD(1'b1)) u_dec_ifid (.instr(ifid_instr),  .dec(dec_ifid));
    hzfwd_decode #(.INSTR_W(INSTR_W), .LOAD_FWD(1'b1)) u_dec_idex (.instr(idex_instr),  .dec(dec_idex));
    // R8: a load in EX/MEM has no data yet, so it is not a source
    hzfwd_decode #(.INSTR_W(INSTR_W), .LOAD_FWD(1'b0)) u_dec_em   (.instr(exmem_instr), .dec(dec_em));
    hzfwd_decode #(.INSTR_W(INSTR_W), .LOAD_FWD(1'b1)) u_dec_mw   (.instr(memwb_instr), .dec(dec_mw));
    hzfwd_decode #(.INSTR_W(INSTR_W), .LOAD_FWD(1'b1)) u_dec_wb   (.instr(wbend_instr), .dec(dec_wb));

    hzfwd_stall u_stall (.front(dec_ifid), .back(dec_idex), .stall(stall));

    logic [NUM_SRC-1:0] src_ok;
    logic [IDX_W-1:0]   src_dst [NUM_SRC];
    logic [DATA_W-1:0]  src_val [NUM_SRC];
    logic [IDX_W-1:0]   want    [NUM_OPND];
    logic [DATA_W-1:0]  rf_val  [NUM_OPND];
    logic [DATA_W-1:0]  res     [NUM_OPND];

    always_comb begin
        src_ok[SRC_WB]  = dec_wb.wr;
        src_ok[SRC_MW]  = dec_mw.wr;
        src_ok[SRC_EM]  = dec_em.wr;
        src_dst[SRC_WB] = dec_wb.dst;
        src_dst[SRC_MW] = dec_mw.dst;
        src_dst[SRC_EM] = dec_em.dst;
        src_val[SRC_WB] = wbend_wdata;
        src_val[SRC_MW] = memwb_wdata;
        src_val[SRC_EM] = exmem_alu;
        want[0]   = dec_idex.ra;
        want[1]   = dec_idex.rb;
        rf_val[0] = rf_a;
        rf_val[1] = rf_b;
    end

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        hzfwd_pick #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_pick (
            .want    (want[g]),
            .rf_val  (rf_val[g]),
            .src_ok  (src_ok),
            .src_dst (src_dst),
            .src_val (src_val),
            .picked  (res[g])
        );
    end

    assign opnd_a = res[0];
    assign opnd_b = res[1];

    always_comb begin
        if (stall)
            assert_stall_needs_load_R1: assert (dec_idex.opc == OP_LOAD)
                else $error("stall without load in ID/EX");
        if ((dec_idex.opc == OP_LOAD) &&
            ((dec_idex.rb == dec_ifid.ra) || (dec_idex.rb == dec_ifid.rb)))
            assert_stall_on_match_R2: assert (stall)
                else $error("load-use match without stall");
        if (dec_em.wr && (dec_em.dst == dec_idex.ra))
            assert_youngest_wins_R6: assert (opnd_a == exmem_alu)
                else $error("EX/MEM match did not win");
        assert_no_load_em_R8: assert (!(dec_em.wr && (dec_em.opc == OP_LOAD)))
            else $error("load in EX/MEM offered as source");
        if (!(dec_em.wr && dec_em.dst == dec_idex.rb) &&
            !(dec_mw.wr && dec_mw.dst == dec_idex.rb) &&
            !(dec_wb.wr && dec_wb.dst == dec_idex.rb))
            assert_passthrough_R4: assert (opnd_b == rf_b)
                else $error("operand B altered without a match");
    end
endmodule

// File: tb/tb_hzfwd_unit.sv
module tb_hzfwd_unit;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    localparam logic [31:0] NOP_W = 32'h01c0_0000;

    logic [31:0] ifid = NOP_W, idex = NOP_W, em = NOP_W, mw = NOP_W, wb = NOP_W;
    logic [31:0] em_alu = '0, mw_wd = '0, wb_wd = '0, rfa = '0, rfb = '0;
    logic        stall;
    logic [31:0] oa, ob;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    hzfwd_unit dut (
        .ifid_instr(ifid), .idex_instr(idex), .exmem_instr(em),
        .memwb_instr(mw), .wbend_instr(wb),
        .exmem_alu(em_alu), .memwb_wdata(mw_wd), .wbend_wdata(wb_wd),
        .rf_a(rfa), .rf_b(rfb),
        .stall(stall), .opnd_a(oa), .opnd_b(ob)
    );

    function automatic logic [31:0] mk(int op, int ra, int rb, logic [15:0] low);
        return {7'd0, op[2:0], ra[2:0], rb[2:0], low};
    endfunction

    // R3: writer opcodes and their destination fields
    function automatic logic [3:0] dst_of(logic [31:0] w, bit load_ok);
        logic [2:0] op = w[24:22];
        if (op == 3'd0 || op == 3'd1) return {1'b1, w[2:0]};
        if (op == 3'd2 && load_ok)    return {1'b1, w[18:16]};
        return 4'd0;
    endfunction

    function automatic logic [31:0] model(logic [2:0] idx, logic [31:0] rf);
        logic [31:0] v = rf;
        logic [3:0]  d;
        d = dst_of(wb, 1'b1); if (d[3] && d[2:0] == idx) v = wb_wd;
        d = dst_of(mw, 1'b1); if (d[3] && d[2:0] == idx) v = mw_wd;
        d = dst_of(em, 1'b0); if (d[3] && d[2:0] == idx) v = em_alu;
        return v;
    endfunction

    function automatic logic model_stall();
        return (idex[24:22] == 3'd2) &&
               ((idex[18:16] == ifid[21:19]) || (idex[18:16] == ifid[18:16]));
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(string tag);
        @(negedge clk);
        #1;
        check({tag, " stall R1/R2"}, {31'd0, stall}, {31'd0, model_stall()});
        check({tag, " opnd_a"}, oa, model(idex[21:19], rfa));
        check({tag, " opnd_b"}, ob, model(idex[18:16], rfb));
    endtask

    task automatic set_data();
        em_alu = 32'hE000_0000 | $urandom;
        mw_wd  = 32'h0A00_0000 ^ $urandom;
        wb_wd  = $urandom;
        rfa    = $urandom;
        rfb    = $urandom;
    endtask

    task automatic clear_stages();
        ifid = NOP_W; idex = NOP_W; em = NOP_W; mw = NOP_W; wb = NOP_W;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Idle state: all no-ops, operands pass through (R4, R9)
        rfa = 32'h1111_1111; rfb = 32'h2222_2222;
        apply("idle R4 R9");

        // R5 R7: every source pairing for the two operands
        for (int sa = 0; sa < 4; sa++) begin
            for (int sb = 0; sb < 4; sb++) begin
                int rb_sel;
                clear_stages();
                set_data();
                rb_sel = (sa == sb && sa != 0) ? 1 : 2;
                idex = mk(0, 1, rb_sel, 16'h0007);
                if (sa == 1) em = mk(0, 5, 6, 16'h0001);
                if (sa == 2) mw = mk(1, 5, 6, 16'h0001);
                if (sa == 3) wb = mk(0, 5, 6, 16'h0001);
                if (sb != sa) begin
                    if (sb == 1) em = mk(1, 4, 3, 16'h0002);
                    if (sb == 2) mw = mk(2, 4, 2, 16'h0000);
                    if (sb == 3) wb = mk(2, 4, 2, 16'h0000);
                end
                apply("pair R5 R7");
            end
        end

        // R6: all three write register 3, EX/MEM wins, then MEM/WB
        clear_stages(); set_data();
        idex = mk(1, 3, 3, 0);
        em = mk(0, 0, 0, 16'h0003); mw = mk(2, 0, 3, 0); wb = mk(1, 0, 0, 16'h0003);
        apply("youngest R6");
        em = mk(3, 0, 3, 16'h0003);
        apply("mw over wb R6");

        // R8: load in EX/MEM skipped, falls back to older source
        clear_stages(); set_data();
        idex = mk(0, 4, 5, 0);
        em = mk(2, 0, 4, 0); wb = mk(0, 0, 0, 16'h0004);
        apply("em load R8");

        // R9: non-writers with matching low bits
        for (int op = 3; op < 8; op++) begin
            clear_stages(); set_data();
            idex = mk(0, 6, 6, 0);
            em = mk(op, 6, 6, 16'h0006); mw = mk(op, 6, 6, 16'h0006); wb = mk(op, 6, 6, 16'h0006);
            apply("non-writer R9");
        end

        // R1 R2: stall cases
        clear_stages(); idex = mk(2, 0, 3, 0); ifid = mk(0, 3, 1, 0); apply("stall ra R2");
        ifid = mk(7, 1, 3, 0); apply("stall rb R2");
        ifid = mk(0, 1, 2, 16'h0003); apply("no stall R2");
        idex = mk(3, 0, 3, 0); ifid = mk(0, 3, 3, 0); apply("store no stall R1");

        // Random mix
        for (int k = 0; k < 1500; k++) begin
            ifid = mk($urandom_range(7), $urandom_range(7), $urandom_range(7), 16'($urandom));
            idex = mk($urandom_range(7), $urandom_range(7), $urandom_range(7), 16'($urandom));
            em   = mk($urandom_range(7), $urandom_range(7), $urandom_range(7), 16'($urandom));
            mw   = mk($urandom_range(7), $urandom_range(7), $urandom_range(7), 16'($urandom));
            wb   = mk($urandom_range(7), $urandom_range(7), $urandom_range(7), 16'($urandom));
            set_data();
            apply("random R3 R5 R6");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule